// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block merges the event sources of a serial receiver/transmitter into one active-high, level-sensitive interrupt request. It also gives a 4-bit cause code that names the most urgent pending and enabled source. There are five causes. A receive error latches a line-status cause. The receive queue reaching its threshold raises a data-ready cause. A receive queue that holds data but sees no activity for a set number of character times raises a stall (timeout) cause. An empty transmit holding stage raises a transmit-ready cause. A change on the modem control lines latches a modem cause.

The surrounding UART supplies the queue fill level, the threshold, one-cycle pulses for character arrival, character read, character-time tick, transmit write and the various status reads, plus the level of the transmit-empty condition. A 4-bit enable register is loaded by a write strobe. Each cause clears when the condition that raised it is serviced: the matching status register is read, the receive data is read, new transmit data is written, or the cause code is read while it reports transmit-ready.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after reset, `irq` is 0, `irq_id` is 4'b0001 and all four enables are 0.
- R2: A cycle with `en_wr` high loads `en_wdata` into the enables. Bit 0 gates data-ready and stall, bit 1 gates transmit-ready, bit 2 gates line-status and bit 3 gates modem. A cause whose enable is 0 never shows in `irq` or `irq_id`.
- R3: A `line_err` pulse latches the line-status cause, which is reported as 4'b0110. The cause stays until a cycle with `line_stat_rd` high. A new `line_err` in the same cycle as the read wins.
- R4: The data-ready cause (4'b0100) is present combinationally whenever `rx_level` is nonzero and `rx_level >= rx_trig`.
- R5: A stall counter counts `char_tick` pulses while `rx_level` is nonzero and neither `rx_push` nor `rx_pop` is high. It is zeroed by `rx_push`, by `rx_pop` or by an empty queue. After TO_CHARS counted ticks, the stall cause (4'b1100) is pending, and it takes precedence over data-ready.
- R6: The transmit-ready cause (4'b0010) is latched when `tx_empty` rises. It is also latched when an enable write turns bit 1 from 0 to 1 while `tx_empty` is high.
- R7: The transmit-ready cause is cleared by `tx_wr`, or by `id_rd` in a cycle where `irq_id` reads 4'b0010. A clear wins over a set in the same cycle. An `id_rd` while another code is shown leaves the cause pending.
- R8: A `modem_chg` pulse latches the modem cause (4'b0000). It is held until `modem_stat_rd`, and a new change in the same cycle as the read wins.
- R9: `irq` is high exactly when some enabled cause is pending, which is exactly when `irq_id` differs from 4'b0001.
- R10: The priority from highest to lowest is line-status, then stall, then data-ready, then transmit-ready, then modem.
- R11: A latched cause whose enable is 0 keeps its state and appears as soon as its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | New enable bits |
| line_err | input | 1 | Pulse: receive error detected |
| line_stat_rd | input | 1 | Pulse: line status read |
| rx_level | input | LVL_W (5) | Receive queue fill level |
| rx_trig | input | LVL_W (5) | Receive threshold |
| rx_push | input | 1 | Pulse: character entered the receive queue |
| rx_pop | input | 1 | Pulse: character read from the receive queue |
| char_tick | input | 1 | Pulse: one character time elapsed |
| tx_empty | input | 1 | Level: transmit holding stage empty |
| tx_wr | input | 1 | Pulse: new transmit data written |
| id_rd | input | 1 | Pulse: cause code read |
| modem_chg | input | 1 | Pulse: modem line change |
| modem_stat_rd | input | 1 | Pulse: modem status read |
| irq | output | 1 | Interrupt request, active high |
| irq_id | output | 4 | Code of the top pending cause |

## Verification
A wrong latched flag or a stale stall count shows up at the ports within one cycle, but only while no higher cause masks it. For this reason the stimulus repeatedly services the higher causes so that lower ones reach `irq_id`. A counter that is off by one tick moves the 4'b1100 code one cycle early or late, and the cycle-by-cycle comparison catches this. A bad clear rule for transmit-ready only appears when `id_rd` lands while a different code is shown, so the directed part builds that case on purpose.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_MODEM  = 4'b0000,
        ID_NONE   = 4'b0001,
        ID_TXE    = 4'b0010,
        ID_RXDATA = 4'b0100,
        ID_LINE   = 4'b0110,
        ID_STALL  = 4'b1100
    } irq_id_e;

    // enable register layout, MSB first
    typedef struct packed {
        logic modem;
        logic line;
        logic txe;
        logic rxdata;
    } irq_en_t;

    typedef struct packed {
        logic line;
        logic stall;
        logic rxdata;
        logic txe;
        logic modem;
    } irq_src_t;

    localparam int FLAG_LINE  = 0;
    localparam int FLAG_MODEM = 1;
    localparam int NUM_FLAGS  = 2;

    function automatic irq_src_t mask_src(irq_src_t s, irq_en_t e);
        irq_src_t m;
        m.line   = s.line   & e.line;
        m.stall  = s.stall  & e.rxdata;
        m.rxdata = s.rxdata & e.rxdata;
        m.txe    = s.txe    & e.txe;
        m.modem  = s.modem  & e.modem;
        return m;
    endfunction

    function automatic irq_id_e pick_id(irq_src_t m);
        if (m.line)        return ID_LINE;
        else if (m.stall)  return ID_STALL;
        else if (m.rxdata) return ID_RXDATA;
        else if (m.txe)    return ID_TXE;
        else if (m.modem)  return ID_MODEM;
        else               return ID_NONE;
    endfunction

endpackage

// File: rtl/irq_flag.sv
module irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (set)  q <= 1'b1;
        else if (clr)  q <= 1'b0;
    end

    AST_FLAG_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        set |=> q); // R3 (and R8)
    AST_FLAG_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q); // R8 (and R3)
endmodule

// File: rtl/irq_rx_timer.sv
module irq_rx_timer #(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_CHARS   = 4,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
    localparam int TW    = $clog2(TO_CHARS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    output logic             data_rdy,
    output logic             stall
);
    localparam logic [TW-1:0] LIM = TW'(TO_CHARS);

    logic [TW-1:0] cnt;
    logic          quiet;

    assign quiet = (rx_level != '0) && !rx_push && !rx_pop;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (!quiet)               cnt <= '0;
        else if (char_tick && cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign stall    = (cnt == LIM);
    assign data_rdy = (rx_level != '0) && (rx_level >= rx_trig);

    AST_STALL_ACTIVITY_CLR: assert property (@(posedge clk) disable iff (rst)
        (rx_push || rx_pop) |=> !stall); // R5
    AST_STALL_EMPTY_CLR: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |=> !stall); // R5
endmodule

// File: rtl/irq_txe_track.sv
module irq_txe_track (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic arm,
    input  logic tx_wr,
    input  logic id_ack,
    output logic pend
);
    logic prev_empty;
    logic set_req;
    logic clr_req;

    assign set_req = (tx_empty && !prev_empty) || (arm && tx_empty);
    assign clr_req = tx_wr || id_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_empty <= 1'b0;
            pend       <= 1'b0;
        end else begin
            prev_empty <= tx_empty;
            if (clr_req)      pend <= 1'b0;
            else if (set_req) pend <= 1'b1;
        end
    end

    AST_TXE_WRITE_CLR: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> !pend); // R7
    AST_TXE_ARM_SET: assert property (@(posedge clk) disable iff (rst)
        (arm && tx_empty && !tx_wr && !id_ack) |=> pend); // R6
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  irq_src_t   src,
    input  irq_en_t    en,
    output logic       irq,
    output logic [3:0] id
);
    irq_src_t masked;

    always_comb begin
        masked = mask_src(src, en);
        id     = pick_id(masked);
        irq    = |masked;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_CHARS   = 4,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic [3:0]       en_wdata,
    input  logic             line_err,
    input  logic             line_stat_rd,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic             tx_empty,
    input  logic             tx_wr,
    input  logic             id_rd,
    input  logic             modem_chg,
    input  logic             modem_stat_rd,
    output logic             irq,
    output logic [3:0]       irq_id
);
    irq_en_t  en_q;
    irq_en_t  en_new;
    irq_src_t src;

    logic [NUM_FLAGS-1:0] f_set;
    logic [NUM_FLAGS-1:0] f_clr;
    logic [NUM_FLAGS-1:0] f_q;

    logic data_rdy;
    logic stall;
    logic txe_pend;
    logic txe_arm;
    logic txe_ack;

    assign en_new = irq_en_t'(en_wdata);

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= en_new;
    end

    assign f_set[FLAG_LINE]  = line_err;
    assign f_clr[FLAG_LINE]  = line_stat_rd;
    assign f_set[FLAG_MODEM] = modem_chg;
    assign f_clr[FLAG_MODEM] = modem_stat_rd;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        irq_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (f_set[g]),
            .clr (f_clr[g]),
            .q   (f_q[g])
        );
    end

    irq_rx_timer #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .TO_CHARS   (TO_CHARS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .rx_level  (rx_level),
        .rx_trig   (rx_trig),
        .rx_push   (rx_push),
        .rx_pop    (rx_pop),
        .char_tick (char_tick),
        .data_rdy  (data_rdy),
        .stall     (stall)
    );

    assign txe_arm = en_wr && en_new.txe && !en_q.txe;
    assign txe_ack = id_rd && (irq_id == ID_TXE);

    irq_txe_track u_txe (
        .clk      (clk),
        .rst      (rst),
        .tx_empty (tx_empty),
        .arm      (txe_arm),
        .tx_wr    (tx_wr),
        .id_ack   (txe_ack),
        .pend     (txe_pend)
    );

    always_comb begin
        src.line   = f_q[FLAG_LINE];
        src.stall  = stall;
        src.rxdata = data_rdy;
        src.txe    = txe_pend;
        src.modem  = f_q[FLAG_MODEM];
    end

    irq_prio_enc u_enc (
        .src (src),
        .en  (en_q),
        .irq (irq),
        .id  (irq_id)
    );

    AST_IRQ_ID_AGREE: assert property (@(posedge clk) disable iff (rst)
        irq == (irq_id != ID_NONE)); // R9
    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (en_q.line && f_q[FLAG_LINE]) |-> (irq_id == ID_LINE)); // R10
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq); // R2
    AST_WRITE_LOADS_EN: assert property (@(posedge clk) disable iff (rst)
        (en_wr && en_wdata == 4'b0000) |=> !irq); // R2
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int TOC   = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 0;
    logic rst = 1;
    logic en_wr = 0;
    logic [3:0] en_wdata = 0;
    logic line_err = 0, line_stat_rd = 0;
    logic [LW-1:0] rx_level = 0, rx_trig = 0;
    logic rx_push = 0, rx_pop = 0, char_tick = 0;
    logic tx_empty = 0, tx_wr = 0, id_rd = 0;
    logic modem_chg = 0, modem_stat_rd = 0;
    logic irq;
    logic [3:0] irq_id;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    bit m_ls, m_ms, m_txe, m_prev;
    int m_cnt;
    bit [3:0] m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl #(.FIFO_DEPTH(DEPTH), .TO_CHARS(TOC)) u0 (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
        .line_err(line_err), .line_stat_rd(line_stat_rd),
        .rx_level(rx_level), .rx_trig(rx_trig), .rx_push(rx_push),
        .rx_pop(rx_pop), .char_tick(char_tick), .tx_empty(tx_empty),
        .tx_wr(tx_wr), .id_rd(id_rd), .modem_chg(modem_chg),
        .modem_stat_rd(modem_stat_rd), .irq(irq), .irq_id(irq_id)
    );

    function automatic bit [3:0] model_id();
        int lvl = int'(rx_level);
        if (m_ls && m_en[2])                       return 4'b0110;
        if (m_en[0] && m_cnt == TOC)               return 4'b1100;
        if (m_en[0] && lvl != 0 && lvl >= int'(rx_trig)) return 4'b0100;
        if (m_txe && m_en[1])                      return 4'b0010;
        if (m_ms && m_en[3])                       return 4'b0000;
        return 4'b0001;
    endfunction

    function automatic string tag_of(bit [3:0] id);
        case (id)
            4'b0110: return "R3";
            4'b1100: return "R5";
            4'b0100: return "R4";
            4'b0010: return "R6";
            4'b0000: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        bit [3:0] cur;
        bit set_t, clr_t;
        started <= 1;
        if (rst) begin
            m_ls = 0; m_ms = 0; m_txe = 0; m_prev = 0; m_cnt = 0; m_en = 0;
        end else begin
            cur = model_id();
            m_ls = line_err ? 1'b1 : (line_stat_rd ? 1'b0 : m_ls);
            m_ms = modem_chg ? 1'b1 : (modem_stat_rd ? 1'b0 : m_ms);
            set_t = (tx_empty && !m_prev) ||
                    (en_wr && en_wdata[1] && !m_en[1] && tx_empty);
            clr_t = tx_wr || (id_rd && cur == 4'b0010);
            if (clr_t) m_txe = 0; else if (set_t) m_txe = 1;
            if (rx_level == 0 || rx_push || rx_pop) m_cnt = 0;
            else if (char_tick && m_cnt < TOC) m_cnt = m_cnt + 1;
            m_prev = tx_empty;
            if (en_wr) m_en = en_wdata;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit [3:0] e;
        if (started && !done) begin
            e = rst ? 4'b0001 : model_id();
            checks += 2;
            if (irq_id !== e) begin
                fails++;
                $display("FAIL %s cycle-compare irq_id actual=%b expected=%b", tag_of(e), irq_id, e);
            end
            if (irq !== (e != 4'b0001)) begin
                fails++;
                $display("FAIL R9 cycle-compare irq actual=%b expected=%b", irq, (e != 4'b0001));
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, bit [3:0] eid);
        @(negedge clk);
        checks++;
        if (irq_id !== eid || irq !== (eid != 4'b0001)) begin
            fails++;
            $display("FAIL %s directed irq_id/irq actual=%b/%b expected=%b/%b",
                     tag, irq_id, irq, eid, (eid != 4'b0001));
        end
    endtask

    task automatic write_en(bit [3:0] v);
        en_wr = 1; en_wdata = v; step(); en_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", 4'b0001);                // in reset
        rst = 0; step();
        chk("R1", 4'b0001);                // first cycle out of reset

        // R11 / R2: transmit-ready latched while disabled
        tx_empty = 1; step();
        chk("R2", 4'b0001);
        write_en(4'b0010);
        chk("R11", 4'b0010);
        id_rd = 1; step(); id_rd = 0;
        chk("R7", 4'b0001);                // read of code while 0010 clears
        // R6: re-arm by enable 0 -> 1 with tx_empty held high
        write_en(4'b0000);
        write_en(4'b0010);
        chk("R6", 4'b0010);
        tx_wr = 1; step(); tx_wr = 0;
        chk("R7", 4'b0001);

        // modem and line status ordering
        write_en(4'b1111);
        chk("R6", 4'b0001);                // bit1 already set: no re-arm
        modem_chg = 1; step(); modem_chg = 0;
        chk("R8", 4'b0000);
        line_err = 1; step(); line_err = 0;
        chk("R10", 4'b0110);
        line_stat_rd = 1; line_err = 1; step(); line_err = 0; line_stat_rd = 0;
        chk("R3", 4'b0110);                // new error wins over read
        line_stat_rd = 1; step(); line_stat_rd = 0;
        chk("R3", 4'b0000);
        modem_stat_rd = 1; step(); modem_stat_rd = 0;
        chk("R8", 4'b0001);

        // stall timer
        rx_trig = 4; rx_level = 2; step();
        chk("R4", 4'b0001);                // below threshold
        for (int i = 0; i < TOC - 1; i++) begin
            char_tick = 1; step(); char_tick = 0; step();
        end
        chk("R5", 4'b0001);                // one tick short
        char_tick = 1; step(); char_tick = 0;
        chk("R5", 4'b1100);
        rx_pop = 1; rx_level = 1; step(); rx_pop = 0;
        chk("R5", 4'b0001);                // read clears stall
        rx_level = 5; step();
        chk("R4", 4'b0100);
        for (int i = 0; i < TOC; i++) begin
            char_tick = 1; step(); char_tick = 0;
        end
        chk("R10", 4'b1100);               // stall over data-ready
        rx_push = 1; rx_level = 6; step(); rx_push = 0;
        chk("R5", 4'b0100);
        rx_level = 0; step();
        chk("R4", 4'b0001);

        // id_rd while another code shows leaves transmit-ready
        tx_empty = 0; step();
        line_err = 1; tx_empty = 1; step(); line_err = 0;
        chk("R10", 4'b0110);
        id_rd = 1; step(); id_rd = 0;
        chk("R7", 4'b0110);
        line_stat_rd = 1; step(); line_stat_rd = 0;
        chk("R7", 4'b0010);
        tx_wr = 1; step(); tx_wr = 0;
        chk("R7", 4'b0001);

        // R11: line status latched while masked
        write_en(4'b1011);
        line_err = 1; step(); line_err = 0;
        chk("R2", 4'b0001);
        write_en(4'b1111);
        chk("R11", 4'b0110);
        line_stat_rd = 1; step(); line_stat_rd = 0;

        // randomized phase, checked by the per-cycle model compare
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) rx_trig = LW'(1 + ($urandom % 14));
            en_wr         = ($urandom % 16) == 0;
            en_wdata      = 4'($urandom);
            line_err      = ($urandom % 24) == 0;
            line_stat_rd  = ($urandom % 8) == 0;
            modem_chg     = ($urandom % 24) == 0;
            modem_stat_rd = ($urandom % 8) == 0;
            if (($urandom % 10) == 0) rx_level = LW'($urandom % (DEPTH + 1));
            rx_push       = ($urandom % 12) == 0;
            rx_pop        = ($urandom % 12) == 0;
            char_tick     = ($urandom % 3) == 0;
            if (($urandom % 10) == 0) tx_empty = ~tx_empty;
            tx_wr         = ($urandom % 14) == 0;
            id_rd         = ($urandom % 5) == 0;
            step();
        end
        en_wr = 0; line_err = 0; line_stat_rd = 0; modem_chg = 0;
        modem_stat_rd = 0; rx_push = 0; rx_pop = 0; char_tick = 0;
        tx_wr = 0; id_rd = 0;
        step();
        @(negedge clk);
        finish_run();
    end
endmodule